// File: doc/BRIEF.md
# Buffered SPI Slave with Dual-Line Receive

This block is an SPI slave that keeps a 1 KiB on-chip byte buffer. A host opens a transaction by pulling chip select low and clocking in a command byte. A write command stores the bytes that follow at consecutive buffer locations, starting from location zero. A read command returns the buffer contents from location zero onward, one bit per clock on the slave output line. The bus runs in mode 3: the clock idles high, the host changes its data on the falling edge, and both sides sample on the rising edge.

A mode input selects how write data arrives. In single-line mode the data comes on one line at one bit per clock. In dual-line mode two bits arrive per clock on two lines, so a byte takes four clocks. The command byte always uses one line, and read data always goes out on one line. The clock, chip select, data lines and mode input pass through two-flop synchronisers into a system clock. That clock must run at least four times the bus clock, and the design is rated for a bus clock of up to 50 MHz.

Top module: `dspi_mem_slave`

## Requirements
- R1: Input data is taken at rising SCLK edges only. The slave output changes only after a rising edge has been seen, so it holds steady across each rising edge at which the host samples it.
- R2: The first 8 clocks of a transaction carry the command, MSB first, on io0_i in both modes. 8'h02 selects write and 8'h03 selects read. Any other value makes the slave ignore the rest of the transaction: nothing is stored and miso_oe_o stays low.
- R3: In single-line write mode (dual_i=0), each data byte takes 8 clocks on io0_i, MSB first. Successive bytes go to buffer locations 0, 1, 2 and so on.
- R4: In dual-line write mode (dual_i=1), each data byte takes 4 clocks. In each clock io1_i carries the higher bit of the pair and io0_i the lower bit, in the order bit pairs (7,6), (5,4), (3,2), (1,0).
- R5: A read sends bytes from location 0 upward on miso_o, MSB first, one bit per clock, whatever the value of dual_i. Bit 7 of byte 0 is valid at the first rising edge after the command byte.
- R6: miso_oe_o is high only during the data phase of a read while chip select is asserted. Whenever miso_oe_o is low, miso_o is 0.
- R7: Raising cs_ni ends the transaction and discards any partial byte, so the buffer location it would have filled keeps its old value. The next transaction starts again with a command byte.
- R8: The buffer holds 1024 bytes. The address pointer wraps from 1023 to 0, so byte number 1024 of a write lands at location 0.
- R9: While rst_ni is low, miso_o and miso_oe_o are 0.
- R10: Buffer contents persist across transactions. A later read returns the bytes stored by an earlier write unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock, idles high |
| cs_ni | input | 1 | Chip select, active low |
| io0_i | input | 1 | Host data line 0 (command, single-line data, low bit of each dual pair) |
| io1_i | input | 1 | Host data line 1 (high bit of each dual pair) |
| dual_i | input | 1 | 1 selects two-bit-per-clock write data |
| miso_o | output | 1 | Slave serial output |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
Several corner cases get directed tests. The first is the first read bit right after the command, where a design that loads its output byte late returns every byte shifted by one bit. The next is dual-line writes, where swapping the two lines or counting eight clocks per byte scrambles the stored data. The bench also aborts a byte partway through, which a design that keeps the bit counter across transactions would store or misalign. It sends an unknown command, which a careless decoder would treat as a write. Last, it writes 1025 bytes to catch a pointer that fails to wrap to location 0. Random-length transfers in mixed modes, checked against a bench copy of the buffer, cover the rest.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ, PH_SKIP} phase_e;
  localparam logic [7:0] CMD_WR = 8'h02;
  localparam logic [7:0] CMD_RD = 8'h03;
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dspi_buf.sv
module dspi_buf #(
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dspi_core.sv
module dspi_core
  import dspi_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          cs_s_i,
  input  logic          io0_s_i,
  input  logic          io1_s_i,
  input  logic          dual_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  input  logic [7:0]    rdata_i,
  output logic          miso_o,
  output logic          miso_oe_o
);
  phase_e        phase;
  logic          sclk_q, rise, load_q, byte_done, dual_step;
  logic [2:0]    bit_cnt;
  logic [3:0]    cnt_sum;
  logic [6:0]    rx_sh;
  logic [7:0]    rx_next, tx_sh;
  logic [AW-1:0] ptr;

  assign rise      = sclk_s_i & ~sclk_q & ~cs_s_i;
  assign dual_step = (phase == PH_WRITE) && dual_s_i;
  assign cnt_sum   = {1'b0, bit_cnt} + (dual_step ? 4'd2 : 4'd1);
  assign byte_done = rise && cnt_sum[3];
  assign rx_next   = dual_step ? {rx_sh[5:0], io1_s_i, io0_s_i}
                               : {rx_sh, io0_s_i};

  assign we_o    = byte_done && (phase == PH_WRITE);
  assign waddr_o = ptr;
  assign wdata_o = rx_next;
  // fetch the next byte at each read boundary, byte 0 right at command end
  assign re_o    = byte_done && ((phase == PH_READ) ||
                                 (phase == PH_CMD && rx_next == CMD_RD));
  assign raddr_o = (phase == PH_CMD) ? '0 : ptr;

  assign miso_oe_o = (phase == PH_READ);
  assign miso_o    = (phase == PH_READ) & tx_sh[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      load_q  <= 1'b0;
    end else if (cs_s_i) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= re_o;
      if (load_q)                         tx_sh <= rdata_i;
      else if (rise && phase == PH_READ)  tx_sh <= {tx_sh[6:0], 1'b0};
      if (rise) begin
        bit_cnt <= cnt_sum[2:0];
        rx_sh   <= rx_next[6:0];
      end
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            if (rx_next == CMD_WR) begin
              phase <= PH_WRITE;
              ptr   <= '0;
            end else if (rx_next == CMD_RD) begin
              phase <= PH_READ;
              ptr   <= AW'(1);
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_WRITE, PH_READ: ptr <= ptr + AW'(1);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dspi_mem_slave.sv
module dspi_mem_slave #(
  parameter int AW         = 10,
  parameter int SYNC_STAGE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic io0_i,
  input  logic io1_i,
  input  logic dual_i,
  output logic miso_o,
  output logic miso_oe_o
);
  logic [4:0]    pins_s;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;

  dspi_sync #(.W(5), .STAGES(SYNC_STAGE), .RST_VAL(5'b00011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dual_i, io1_i, io0_i, cs_ni, sclk_i}),
    .q_o    (pins_s)
  );

  dspi_core #(.AW(AW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (pins_s[0]),
    .cs_s_i    (pins_s[1]),
    .io0_s_i   (pins_s[2]),
    .io1_s_i   (pins_s[3]),
    .dual_s_i  (pins_s[4]),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .re_o      (re),
    .raddr_o   (raddr),
    .rdata_i   (rdata),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
  );

  dspi_buf #(.AW(AW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/dspi_core_chk.sv
module dspi_core_chk
  import dspi_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s_i,
  input logic          dual_s_i,
  input logic          rise,
  input logic          load_q,
  input phase_e        phase,
  input logic [2:0]    bit_cnt,
  input logic [AW-1:0] ptr,
  input logic          we_o,
  input logic          miso_o,
  input logic          miso_oe_o
);
  p_out_moves_after_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_o) |-> ($past(rise) || $past(load_q) || $past(cs_s_i)));

  p_skip_stores_nothing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SKIP) |-> !we_o);

  p_dual_pairs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WRITE && dual_s_i && !cs_s_i) |-> !bit_cnt[0]);

  p_out_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);

  p_cs_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> (bit_cnt == 3'd0 && ptr == '0 && !miso_oe_o));

  p_ptr_steps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !cs_s_i) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

bind dspi_core dspi_core_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s_i    (cs_s_i),
  .dual_s_i  (dual_s_i),
  .rise      (rise),
  .load_q    (load_q),
  .phase     (phase),
  .bit_cnt   (bit_cnt),
  .ptr       (ptr),
  .we_o      (we_o),
  .miso_o    (miso_o),
  .miso_oe_o (miso_oe_o)
);

// File: tb/dspi_mem_slave_test.sv
module dspi_mem_slave_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, io0 = 1'b0, io1 = 1'b0, dual = 1'b0;
  logic miso, miso_oe;
  int   checks = 0, errors = 0;
  logic [7:0] model [1024];

  always #5 clk = ~clk;

  dspi_mem_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n),
    .io0_i(io0), .io1_i(io1), .dual_i(dual),
    .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one SCLK period: fall, drive, wait, sample, rise
  task automatic tick(input logic d1, input logic d0, output logic s);
    sclk = 1'b0; io1 = d1; io0 = d0;
    #40;
    s = miso;
    sclk = 1'b1;
    #40;
  endtask

  task automatic send_single(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) tick(1'b0, b[i], s);
  endtask

  task automatic send_dual(input logic [7:0] b);
    logic s;
    for (int i = 3; i >= 0; i--) tick(b[2*i+1], b[2*i], s);
  endtask

  task automatic recv(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      tick(1'b0, 1'b0, s);
      b[i] = s;
    end
  endtask

  task automatic open_cs();  cs_n = 1'b0; #40; endtask
  task automatic close_cs(); #40; cs_n = 1'b1; #80; endtask

  task automatic do_write(input logic dm, input int n, input string req);
    dual = dm;
    #40;
    open_cs();
    send_single(8'h02);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'($urandom_range(0, 255));
      model[k % 1024] = b;
      if (dm) send_dual(b); else send_single(b);
    end
    close_cs();
  endtask

  task automatic do_read(input logic dm, input int n, input string req);
    logic [7:0] b;
    dual = dm;
    #40;
    open_cs();
    send_single(8'h03);
    for (int k = 0; k < n; k++) begin
      recv(b);
      check(req, b, model[k]);
      if (k == 0) check("R6 oe during read", {7'd0, miso_oe}, 8'd1);
    end
    close_cs();
    check("R6 oe after cs", {7'd0, miso_oe}, 8'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #23;
    check("R9 reset miso", {7'd0, miso}, 8'd0);
    check("R9 reset oe", {7'd0, miso_oe}, 8'd0);
    #7;
    rst_ni = 1'b1;
    #40;

    // R3 R5 R1 R10: single write then single read
    do_write(1'b0, 16, "R3");
    do_read(1'b0, 16, "R3 R5 R1 R10 single");
    // R4: dual write, read still single line
    do_write(1'b1, 16, "R4");
    do_read(1'b1, 16, "R4 R5 dual");

    // random lengths and modes
    for (int it = 0; it < 6; it++) begin
      int n;
      logic mw;
      n  = $urandom_range(1, 12);
      mw = 1'($urandom_range(0, 1));
      do_write(mw, n, "R3 R4 random");
      do_read(~mw, 16, "R10 random");
    end

    // R7: partial byte dropped
    begin
      logic s;
      logic [7:0] b;
      dual = 1'b0;
      #40;
      open_cs();
      send_single(8'h02);
      for (int k = 0; k < 3; k++) begin
        b = 8'($urandom_range(0, 255));
        model[k] = b;
        send_single(b);
      end
      b = ~model[3];
      for (int i = 7; i >= 3; i--) tick(1'b0, b[i], s);
      close_cs();
      do_read(1'b0, 6, "R7 partial byte");
    end

    // R2: unknown command ignored
    begin
      open_cs();
      send_single(8'h5A);
      send_single(8'hFF);
      send_single(8'h00);
      check("R2 oe on bad cmd", {7'd0, miso_oe}, 8'd0);
      check("R2 miso on bad cmd", {7'd0, miso}, 8'd0);
      close_cs();
      do_read(1'b0, 4, "R2 buffer unchanged");
    end

    // R8: wrap after 1024 bytes
    do_write(1'b1, 1025, "R8");
    do_read(1'b0, 3, "R8 wrap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule